// File: doc/BRIEF.md
# Signed Fixed-Point Requantizer

This block narrows a two's-complement sample in a fixed, two-stage pipeline. First it shortens the word at the bottom, dropping a parameterized number of fractional bits and rounding by one of four runtime-selectable schemes. Then it shortens the word at the top to the output width, either by discarding the excess high bits (wrap) or by saturating to the output's extreme values (clip).

The block is meant to sit between arithmetic stages of a datapath, so that every stage uses the same quantization scheme. Samples arrive with a valid strobe. The rounding and overflow selects are captured together with each sample, so the mode may change from one sample to the next. There is no back-pressure: the block accepts a sample on every cycle that `in_valid` is high. Each accepted sample produces exactly one result two cycles later, and the downstream logic must take it in that cycle. An overflow flag marks each result whose rounded value did not fit the output width.

Top module: `fxp_requant`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `out_ovf` and `out_data` are all zero, and a sample still in flight when reset is asserted produces no output.
- R2: A sample accepted at a rising edge with `in_valid` high appears with `out_valid` high exactly two rising edges later. Each accepted sample produces exactly one output cycle, samples may arrive on consecutive cycles, and `out_valid` is low in every cycle that has no matching input.
- R3: With `rnd_mode` = 0 (floor), the dropped low bits are discarded, which is an arithmetic shift right by DROP. Examples: -5/16 gives -1, +5/16 gives 0 and -1.5 gives -2.
- R4: With `rnd_mode` = 1 (half up), an exact half rounds toward plus infinity. Examples: -1.5 gives -1, -0.5 gives 0 and 0.5 gives 1.
- R5: With `rnd_mode` = 2 (half away), an exact half rounds away from zero. Examples: -1.5 gives -2, -0.5 gives -1 and 0.5 gives 1.
- R6: With `rnd_mode` = 3 (half even), an exact half rounds to the nearest even integer. Examples: -1.5 gives -2, -0.5 gives 0, 0.5 gives 0, 1.5 gives 2 and 2.5 gives 2.
- R7: In modes 1, 2 and 3, a fraction that is not an exact half rounds to the nearest integer. Examples: 1.25 gives 1, 1.75 gives 2, -1.25 gives -1 and -1.75 gives -2.
- R8: With `clip_en` = 0, a rounded value outside the output range is reduced to its low OUT_W bits and `out_ovf` is 1. Examples with OUT_W = 8: 200 gives -56, -129 gives 127 and -2048 gives 0.
- R9: With `clip_en` = 1, a rounded value above the output range gives 2^(OUT_W-1)-1 and one below it gives -2^(OUT_W-1), with `out_ovf` = 1. The range limits themselves pass through with `out_ovf` = 0.
- R10: Rounding is applied before the overflow handling. A rounding carry past the maximum (127.5 in half up mode becomes 128) is wrapped to -128 or clipped to 127, with `out_ovf` = 1.
- R11: The `rnd_mode` and `clip_en` values sampled with each input sample govern that sample alone, even when consecutive samples use different modes.
- R12: With DROP = 0, rounding is bypassed and `rnd_mode` has no effect, so only the wrap or clip handling applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | IN_W | Two's-complement input sample |
| rnd_mode | input | 2 | Rounding scheme: 0 floor, 1 half up, 2 half away, 3 half even |
| clip_en | input | 1 | 1 saturates out-of-range results, 0 wraps them |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | OUT_W | Two's-complement requantized sample |
| out_ovf | output | 1 | Rounded value did not fit OUT_W bits |

## Verification
The only state in the block is two pipeline registers: the rounded value with its carry bit and captured clip select, and the output register. A corrupted rounded value or a wrongly captured mode therefore shows up on `out_data` or `out_ovf` one cycle after it forms, in the output cycle that belongs to that sample. It does not affect any later sample. A lost or duplicated valid bit shows up at once as a missing or extra `out_valid` pulse two cycles after the input. The tie cases and the values next to the range limits are where a wrong carry or a wrong fit test would appear, so the stimulus concentrates on exact halves, on the output limits and on the extremes of the input.

// File: rtl/fxp_requant_pkg.sv
package fxp_requant_pkg;

  // Rounding scheme selected per sample.
  typedef enum logic [1:0] {
    RND_FLOOR     = 2'd0,
    RND_HALF_UP   = 2'd1,
    RND_HALF_AWAY = 2'd2,
    RND_HALF_EVEN = 2'd3
  } rnd_mode_e;

endpackage

// File: rtl/fxp_round.sv
// Drops DROP low bits of a signed word with the selected rounding scheme.
// The result keeps one extra high bit so that a rounding carry is preserved.
module fxp_round
  import fxp_requant_pkg::*;
#(
  parameter int IN_W = 16,
  parameter int DROP = 4,
  localparam int KW = IN_W - DROP,
  localparam int RW = KW + 1
) (
  input  logic [IN_W-1:0] din,
  input  rnd_mode_e       mode,
  output logic [RW-1:0]   dout
);

  generate
    if (DROP == 0) begin : g_bypass
      // R12: nothing to round, only widen by one sign bit
      rnd_mode_e unused_mode;
      assign unused_mode = mode;
      assign dout = {din[IN_W-1], din};
    end else begin : g_round
      logic [KW-1:0] kept;
      logic          neg;
      logic          half_bit;
      logic          below_half;
      logic          inc;

      assign kept     = din[IN_W-1:DROP];
      assign neg      = din[IN_W-1];
      assign half_bit = din[DROP-1];

      if (DROP >= 2) begin : g_rest
        assign below_half = |din[DROP-2:0];
      end else begin : g_norest
        assign below_half = 1'b0;
      end

      always_comb begin
        unique case (mode)
          RND_FLOOR:     inc = 1'b0;
          RND_HALF_UP:   inc = half_bit;
          RND_HALF_AWAY: inc = half_bit & (below_half | ~neg);
          RND_HALF_EVEN: inc = half_bit & (below_half | kept[0]);
          default:       inc = 1'b0;
        endcase
      end

      assign dout = {kept[KW-1], kept} + RW'(inc);
    end
  endgenerate

endmodule

// File: rtl/fxp_limit.sv
// Narrows a signed word to OUT_W bits by wrapping or saturating, and flags misfits.
module fxp_limit #(
  parameter int RW    = 13,
  parameter int OUT_W = 8
) (
  input  logic [RW-1:0]    din,
  input  logic             clip,
  output logic [OUT_W-1:0] dout,
  output logic             ovf
);

  generate
    if (OUT_W >= RW) begin : g_widen
      logic unused_clip;
      assign unused_clip = clip;
      assign dout = OUT_W'($signed(din));
      assign ovf  = 1'b0;
    end else begin : g_narrow
      localparam int TOPN = RW - OUT_W + 1;
      logic [TOPN-1:0]  top_bits;
      logic             fits;
      logic [OUT_W-1:0] rail;

      // Fits when the sign bit of the output and every bit above it agree.
      assign top_bits = din[RW-1:OUT_W-1];
      assign fits     = (&top_bits) | ~(|top_bits);
      assign rail     = din[RW-1] ? {1'b1, {(OUT_W-1){1'b0}}}
                                  : {1'b0, {(OUT_W-1){1'b1}}};
      assign dout     = (fits || !clip) ? din[OUT_W-1:0] : rail;
      assign ovf      = ~fits;
    end
  endgenerate

endmodule

// File: rtl/fxp_requant.sv
// Two-stage signed requantizer: round at the bottom, then wrap or clip at the top.
module fxp_requant
  import fxp_requant_pkg::*;
#(
  parameter int IN_W  = 16,
  parameter int DROP  = 4,
  parameter int OUT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_data,
  input  logic [1:0]       rnd_mode,
  input  logic             clip_en,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data,
  output logic             out_ovf
);

  localparam int RW = IN_W - DROP + 1;

  logic [RW-1:0]    rnd_val;
  logic             s1_valid;
  logic [RW-1:0]    s1_val;
  logic             s1_clip;
  logic [OUT_W-1:0] lim_val;
  logic             lim_ovf;

  fxp_round #(.IN_W(IN_W), .DROP(DROP)) u_round (
    .din  (in_data),
    .mode (rnd_mode_e'(rnd_mode)),
    .dout (rnd_val)
  );

  // Stage 1: rounded value with its carry bit, and this sample's clip select.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_val   <= '0;
      s1_clip  <= 1'b0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_val  <= rnd_val;
        s1_clip <= clip_en;
      end
    end
  end

  fxp_limit #(.RW(RW), .OUT_W(OUT_W)) u_limit (
    .din  (s1_val),
    .clip (s1_clip),
    .dout (lim_val),
    .ovf  (lim_ovf)
  );

  // Stage 2: output register.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_ovf   <= 1'b0;
    end else begin
      out_valid <= s1_valid;
      out_ovf   <= s1_valid & lim_ovf;
      if (s1_valid) out_data <= lim_val;
    end
  end

endmodule

// File: rtl/fxp_requant_chk.sv
module fxp_requant_chk #(
  parameter int IN_W  = 16,
  parameter int DROP  = 4,
  parameter int OUT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [IN_W-1:0]  in_data,
  input logic [1:0]       rnd_mode,
  input logic             clip_en,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_data,
  input logic             out_ovf
);

  localparam logic [OUT_W-1:0] OMAX = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] OMIN = {1'b1, {(OUT_W-1){1'b0}}};

  logic signed [IN_W-1:0] floor_full;
  logic [OUT_W-1:0]       floor_lo;
  assign floor_full = $signed(in_data) >>> DROP;
  assign floor_lo   = floor_full[OUT_W-1:0];

  // R2: every accepted sample comes out two cycles later
  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid);

  // R2: no output without a matching input
  a_r2_no_extra: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 2));

  // R8/R9: the overflow flag only accompanies a valid result
  a_r8_ovf_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_ovf |-> out_valid);

  // R9: a clipped overflow sits on one of the rails
  a_r9_clip_rail: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ovf && $past(clip_en, 2)) |->
      (out_data == OMAX || out_data == OMIN));

  // R3: floor with wrap equals the low bits of the arithmetic shift
  a_r3_floor_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(rnd_mode, 2) == 2'd0 && !$past(clip_en, 2)) |->
      out_data == $past(floor_lo, 2));

  // R1: outputs are idle while reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_idle: assert (!out_valid && !out_ovf && out_data == '0);
    end
  end

endmodule

bind fxp_requant fxp_requant_chk #(.IN_W(IN_W), .DROP(DROP), .OUT_W(OUT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .rnd_mode  (rnd_mode),
  .clip_en   (clip_en),
  .out_valid (out_valid),
  .out_data  (out_data),
  .out_ovf   (out_ovf)
);

// File: tb/fxp_requant_bench.sv
module fxp_requant_bench;

  localparam int CLK_PERIOD = 10;
  localparam int IN_W  = 16;
  localparam int DROP  = 4;
  localparam int OUT_W = 8;

  // Vector layout: [31:16] input, [15:14] mode, [13] clip, [12:5] expected, [4] ovf, [3:0] requirement.
  localparam int NV = 37;
  localparam logic [31:0] VEC [NV] = '{
    {16'(-24),   2'd0, 1'b0, 8'(-2),   1'b0, 4'd3},   // R3
    {16'(-8),    2'd0, 1'b0, 8'(-1),   1'b0, 4'd3},   // R3
    {16'(-5),    2'd0, 1'b0, 8'(-1),   1'b0, 4'd3},   // R3
    {16'(5),     2'd0, 1'b0, 8'(0),    1'b0, 4'd3},   // R3
    {16'(-24),   2'd1, 1'b0, 8'(-1),   1'b0, 4'd4},   // R4
    {16'(-8),    2'd1, 1'b0, 8'(0),    1'b0, 4'd4},   // R4
    {16'(8),     2'd1, 1'b0, 8'(1),    1'b0, 4'd4},   // R4
    {16'(40),    2'd1, 1'b0, 8'(3),    1'b0, 4'd4},   // R4
    {16'(-24),   2'd2, 1'b0, 8'(-2),   1'b0, 4'd5},   // R5
    {16'(-8),    2'd2, 1'b0, 8'(-1),   1'b0, 4'd5},   // R5
    {16'(8),     2'd2, 1'b0, 8'(1),    1'b0, 4'd5},   // R5
    {16'(-24),   2'd3, 1'b0, 8'(-2),   1'b0, 4'd6},   // R6
    {16'(-8),    2'd3, 1'b0, 8'(0),    1'b0, 4'd6},   // R6
    {16'(8),     2'd3, 1'b0, 8'(0),    1'b0, 4'd6},   // R6
    {16'(24),    2'd3, 1'b0, 8'(2),    1'b0, 4'd6},   // R6
    {16'(40),    2'd3, 1'b0, 8'(2),    1'b0, 4'd6},   // R6
    {16'(20),    2'd3, 1'b0, 8'(1),    1'b0, 4'd7},   // R7
    {16'(28),    2'd2, 1'b0, 8'(2),    1'b0, 4'd7},   // R7
    {16'(-20),   2'd2, 1'b0, 8'(-1),   1'b0, 4'd7},   // R7
    {16'(-28),   2'd1, 1'b0, 8'(-2),   1'b0, 4'd7},   // R7
    {16'(-20),   2'd3, 1'b0, 8'(-1),   1'b0, 4'd7},   // R7
    {16'(28),    2'd1, 1'b0, 8'(2),    1'b0, 4'd7},   // R7
    {16'(3200),  2'd0, 1'b0, 8'(-56),  1'b1, 4'd8},   // R8
    {16'(-2064), 2'd0, 1'b0, 8'(127),  1'b1, 4'd8},   // R8
    {16'(-32768),2'd0, 1'b0, 8'(0),    1'b1, 4'd8},   // R8
    {16'(32767), 2'd0, 1'b0, 8'(-1),   1'b1, 4'd8},   // R8
    {16'(3200),  2'd0, 1'b1, 8'(127),  1'b1, 4'd9},   // R9
    {16'(-2064), 2'd0, 1'b1, 8'(-128), 1'b1, 4'd9},   // R9
    {16'(32767), 2'd3, 1'b1, 8'(127),  1'b1, 4'd9},   // R9
    {16'(-32768),2'd2, 1'b1, 8'(-128), 1'b1, 4'd9},   // R9
    {16'(2032),  2'd0, 1'b1, 8'(127),  1'b0, 4'd9},   // R9
    {16'(-2048), 2'd0, 1'b1, 8'(-128), 1'b0, 4'd9},   // R9
    {16'(2040),  2'd1, 1'b0, 8'(-128), 1'b1, 4'd10},  // R10
    {16'(2040),  2'd1, 1'b1, 8'(127),  1'b1, 4'd10},  // R10
    {16'(2040),  2'd0, 1'b0, 8'(127),  1'b0, 4'd10},  // R10
    {16'(-2056), 2'd2, 1'b1, 8'(-128), 1'b1, 4'd10},  // R10
    {16'(-2056), 2'd3, 1'b0, 8'(-128), 1'b0, 4'd10}   // R10
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic [IN_W-1:0]  in_data = '0;
  logic [1:0]       rnd_mode = 2'd0;
  logic             clip_en = 1'b0;
  logic             out_valid;
  logic [OUT_W-1:0] out_data;
  logic             out_ovf;

  // Second instance with no dropped bits (R12): 8 bits in, 4 bits out.
  logic       z_valid = 1'b0;
  logic [7:0] z_data = '0;
  logic       z_out_valid;
  logic [3:0] z_out_data;
  logic       z_out_ovf;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fxp_requant #(.IN_W(IN_W), .DROP(DROP), .OUT_W(OUT_W)) u_fxp_requant (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .rnd_mode(rnd_mode), .clip_en(clip_en),
    .out_valid(out_valid), .out_data(out_data), .out_ovf(out_ovf)
  );

  fxp_requant #(.IN_W(8), .DROP(0), .OUT_W(4)) u_fxp_requant_nodrop (
    .clk(clk), .rst_n(rst_n), .in_valid(z_valid), .in_data(z_data),
    .rnd_mode(rnd_mode), .clip_en(clip_en),
    .out_valid(z_out_valid), .out_data(z_out_data), .out_ovf(z_out_ovf)
  );

  task automatic check(input bit ok, input string tag, input int act_v, input int act_d,
                       input int act_o, input int exp_v, input int exp_d, input int exp_o);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual valid=%0d data=%0d ovf=%0d, expected valid=%0d data=%0d ovf=%0d",
               tag, act_v, act_d, act_o, exp_v, exp_d, exp_o);
    end
  endtask

  task automatic check_out(input string tag, input int exp_d, input bit exp_o);
    check(out_valid === 1'b1 && $signed(out_data) == exp_d && out_ovf === exp_o, tag,
          int'(out_valid), int'($signed(out_data)), int'(out_ovf), 1, exp_d, int'(exp_o));
  endtask

  task automatic run_one(input logic [15:0] din, input logic [1:0] m, input bit c,
                         input int exp_d, input bit exp_o, input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_data = din; rnd_mode = m; clip_en = c;
    @(negedge clk);
    in_valid = 1'b0; in_data = '0; rnd_mode = 2'd0; clip_en = 1'b0;
    @(negedge clk);
    check_out(tag, exp_d, exp_o);
  endtask

  task automatic run_zero(input logic [7:0] din, input logic [1:0] m, input bit c,
                          input int exp_d, input bit exp_o);
    @(negedge clk);
    z_valid = 1'b1; z_data = din; rnd_mode = m; clip_en = c;
    @(negedge clk);
    z_valid = 1'b0; rnd_mode = 2'd0; clip_en = 1'b0;
    @(negedge clk);
    check(z_out_valid === 1'b1 && $signed(z_out_data) == exp_d && z_out_ovf === exp_o, "R12",
          int'(z_out_valid), int'($signed(z_out_data)), int'(z_out_ovf), 1, exp_d, int'(exp_o));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: idle outputs during reset
    check(out_valid === 1'b0 && out_data === '0 && out_ovf === 1'b0, "R1 reset",
          int'(out_valid), int'(out_data), int'(out_ovf), 0, 0, 0);
    rst_n = 1'b1;

    // Table walk, each vector sent alone.
    for (int i = 0; i < NV; i++) begin
      run_one(VEC[i][31:16], VEC[i][15:14], VEC[i][13], int'($signed(VEC[i][12:5])),
              VEC[i][4], $sformatf("R%0d vector %0d", VEC[i][3:0], i));
    end

    // R2: gap after a lone sample
    @(negedge clk);
    check(out_valid === 1'b0 && out_ovf === 1'b0, "R2 idle gap",
          int'(out_valid), 0, int'(out_ovf), 0, 0, 0);

    // R11 and R2: back-to-back samples with a different mode each cycle
    @(negedge clk);
    in_valid = 1'b1; in_data = 16'(-8); rnd_mode = 2'd1; clip_en = 1'b0;
    @(negedge clk);
    in_data = 16'(-8); rnd_mode = 2'd2; clip_en = 1'b0;
    @(negedge clk);
    check_out("R11 first of burst", 0, 1'b0);
    in_data = 16'(3200); rnd_mode = 2'd0; clip_en = 1'b1;
    @(negedge clk);
    check_out("R11 second of burst", -1, 1'b0);
    in_data = 16'(3200); rnd_mode = 2'd0; clip_en = 1'b0;
    @(negedge clk);
    check_out("R11 third of burst", 127, 1'b1);
    in_valid = 1'b0;
    @(negedge clk);
    check_out("R2 fourth of burst", -56, 1'b1);
    @(negedge clk);
    check(out_valid === 1'b0, "R2 burst end", int'(out_valid), 0, 0, 0, 0, 0);

    // R1: sample in flight when reset hits is dropped
    @(negedge clk);
    in_valid = 1'b1; in_data = 16'(24); rnd_mode = 2'd3;
    @(negedge clk);
    in_valid = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    check(out_valid === 1'b0 && out_data === '0 && out_ovf === 1'b0, "R1 flush",
          int'(out_valid), int'(out_data), int'(out_ovf), 0, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0, "R1 after flush", int'(out_valid), 0, 0, 0, 0, 0);

    // R12: no dropped bits, mode ignored, only wrap or clip
    run_zero(8'sd7,   2'd3, 1'b0,  7, 1'b0);
    run_zero(8'sd5,   2'd1, 1'b0,  5, 1'b0);
    run_zero(-8'sd3,  2'd2, 1'b0, -3, 1'b0);
    run_zero(8'sd8,   2'd0, 1'b0, -8, 1'b1);
    run_zero(8'sd8,   2'd3, 1'b1,  7, 1'b1);
    run_zero(-8'sd9,  2'd1, 1'b0,  7, 1'b1);
    run_zero(-8'sd9,  2'd2, 1'b1, -8, 1'b1);

    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual run still busy, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule